// File: doc/BRIEF.md
# Flash Write Sequencer with Page Protection

This block takes program and page-erase requests from a processor-side register interface and turns them into timed strobes on a behavioural flash port. The flash holds 64 pages of 2 KB, addressed by a 17-bit byte address. Words are 32 bits wide. A lock byte sets which pages may be altered. A protected request never reaches the flash. It sets a sticky abort flag instead.

Software writes a 6-bit timing value that scales every strobe. A program strobe lasts sixteen clock cycles per timing unit. An erase strobe lasts that long multiplied by a further erase scale. After each word is committed the byte address steps to the next word, and a one-cycle DMA request tells a DMA engine that the next word may be supplied. A word that arrives while the sequencer is busy waits in a single holding slot. In that case the DMA request comes only once the held word has also been committed.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, busy, abort flag, DMA request and both strobes are 0, the byte address is 0 and the timing value is 0x2A.
- R2: With lock size code c (lock byte bits 3:1), every page p with p >= 64 - (64 >> c) is protected. Code 000 protects all pages, 110 protects only page 63, and 111 protects none.
- R3: Page 0 is protected when the boot-open bit (lock byte bit 4) is 0, and also when the size code is 000. Otherwise its protection follows R2.
- R4: A request to a protected page raises neither strobe, issues no DMA request, leaves the byte address unchanged and sets the abort flag.
- R5: The abort flag stays set until a cycle with abort_clr high. That cycle clears it, unless a new rejection sets it in the same cycle.
- R6: An allowed word write holds flash_prog high for exactly timing x 16 cycles. During that pulse flash_waddr equals byte address bits 16:2, and flash_wdata carries the word.
- R7: An allowed page erase holds flash_erase high for exactly timing x 16 x ERASE_SCALE cycles. The page is byte address bits 16:11. The erase leaves the address unchanged and issues no DMA request.
- R8: Each committed word advances the byte address by 4.
- R9: The DMA request is a one-cycle pulse after the last pending word is committed, and busy is low in that cycle.
- R10: A word written while busy is held in one slot and committed afterwards at the next address, and only one DMA request follows both words. A further word that arrives while the slot is full is dropped.
- R11: Timing and address writes are ignored while busy.
- R12: flash_prog and flash_erase are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_cfg | input | 8 | Lock byte: bit 4 boot-open, bits 3:1 size code |
| tim_we | input | 1 | Timing value write strobe |
| tim_wdata | input | 6 | New timing value |
| addr_we | input | 1 | Byte address write strobe |
| addr_wdata | input | 17 | New byte address |
| data_we | input | 1 | Data word write, starts a program |
| data_wdata | input | 32 | Data word |
| erase_start | input | 1 | Start an erase of the addressed page |
| abort_clr | input | 1 | Clears the abort flag |
| timing_val | output | 6 | Current timing value |
| cur_addr | output | 17 | Current byte address |
| busy | output | 1 | Operation in progress |
| abort_flag | output | 1 | Sticky protection-violation flag |
| dma_req | output | 1 | One-cycle word-committed pulse |
| flash_waddr | output | 15 | Word address to the flash |
| flash_wdata | output | 32 | Data word to the flash |
| flash_prog | output | 1 | Program strobe |
| flash_erase | output | 1 | Page erase strobe |

## Verification
Random lock bytes, pages and operation kinds are checked against a bench model of the protection rule. This separates threshold errors in the size-code decode from errors in the page-0 rule. Directed cases cover codes 000, 110 and 111 with each boot-open setting at pages 0, 62 and 63, where an off-by-one in the boundary shows first. Back-to-back words, including a third word sent while the slot is full, separate correct holding from lost or duplicated writes and early DMA requests. Timing values 3 and 0x15 show whether the pulse length actually scales with the register.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_PROG, ST_ERASE, ST_DONE, ST_REJECT
  } fstate_t;

  typedef enum logic {
    OP_WRITE, OP_ERASE
  } op_t;
endpackage

// File: rtl/flash_page_guard.sv
module flash_page_guard #(
  parameter int PAGE_W = 6
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [2:0]        size_code,
  input  logic              boot_open,
  output logic              locked
);
  localparam int NPAGES = 1 << PAGE_W;

  logic [PAGE_W:0] first_locked;

  always_comb begin
    // lowest protected page: size code halves the protected span per step
    first_locked = (PAGE_W+1)'(NPAGES) - ((PAGE_W+1)'(NPAGES) >> size_code);
    locked = ({1'b0, page} >= first_locked) ||
             ((page == '0) && (!boot_open || (size_code == 3'b000)));
  end
endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && (cnt > CNT_W'(1))) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expire = (cnt <= CNT_W'(1));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int DW          = 32,
  parameter int ADDR_W      = 17,
  parameter int PAGE_W      = 6,
  parameter int TIM_W       = 6,
  parameter int TIM_RESET   = 42,
  parameter int PROG_SCALE  = 16,
  parameter int ERASE_SCALE = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        lock_cfg,
  input  logic              tim_we,
  input  logic [TIM_W-1:0]  tim_wdata,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              data_we,
  input  logic [DW-1:0]     data_wdata,
  input  logic              erase_start,
  input  logic              abort_clr,
  output logic [TIM_W-1:0]  timing_val,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              busy,
  output logic              abort_flag,
  output logic              dma_req,
  output logic [ADDR_W-3:0] flash_waddr,
  output logic [DW-1:0]     flash_wdata,
  output logic              flash_prog,
  output logic              flash_erase
);
  localparam int WB       = $clog2(DW / 8);
  localparam int PAGE_LSB = ADDR_W - PAGE_W;
  localparam int MAX_LEN  = ((1 << TIM_W) - 1) * PROG_SCALE * ERASE_SCALE;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DW / 8);

  fstate_t          state;
  op_t              op;
  logic             hold_vld;
  logic [DW-1:0]    hold_data;
  logic             locked;
  logic             tmr_load;
  logic             tmr_expire;
  logic [CNT_W-1:0] pulse_len;
  logic             lock_unused;

  assign lock_unused = ^{lock_cfg[7:5], lock_cfg[0]};

  flash_page_guard #(.PAGE_W(PAGE_W)) u_guard (
    .page      (cur_addr[ADDR_W-1:PAGE_LSB]),
    .size_code (lock_cfg[3:1]),
    .boot_open (lock_cfg[4]),
    .locked    (locked)
  );

  always_comb begin
    pulse_len = CNT_W'(timing_val) * CNT_W'(PROG_SCALE);
    if (op == OP_ERASE) pulse_len = pulse_len * CNT_W'(ERASE_SCALE);
  end

  assign tmr_load = (state == ST_CHECK) && !locked;

  flash_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (pulse_len),
    .run      ((state == ST_PROG) || (state == ST_ERASE)),
    .expire   (tmr_expire)
  );

  assign flash_waddr = cur_addr[ADDR_W-1:WB];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op          <= OP_WRITE;
      hold_vld    <= 1'b0;
      hold_data   <= '0;
      timing_val  <= TIM_W'(TIM_RESET);
      cur_addr    <= '0;
      busy        <= 1'b0;
      abort_flag  <= 1'b0;
      dma_req     <= 1'b0;
      flash_wdata <= '0;
      flash_prog  <= 1'b0;
      flash_erase <= 1'b0;
    end else begin
      dma_req <= 1'b0;

      if (tim_we && !busy) timing_val <= tim_wdata;
      if (addr_we && !busy) cur_addr <= addr_wdata;

      if (state == ST_REJECT) abort_flag <= 1'b1;
      else if (abort_clr)     abort_flag <= 1'b0;

      // holding slot fills only while an operation is underway
      if (data_we && !hold_vld &&
          ((state == ST_CHECK) || (state == ST_PROG) || (state == ST_ERASE))) begin
        hold_vld  <= 1'b1;
        hold_data <= data_wdata;
      end

      unique case (state)
        ST_IDLE: begin
          if (data_we) begin
            op          <= OP_WRITE;
            flash_wdata <= data_wdata;
            busy        <= 1'b1;
            state       <= ST_CHECK;
          end else if (erase_start) begin
            op    <= OP_ERASE;
            busy  <= 1'b1;
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (locked)               state <= ST_REJECT;
          else if (op == OP_ERASE) begin
            flash_erase <= 1'b1;
            state       <= ST_ERASE;
          end else begin
            flash_prog <= 1'b1;
            state      <= ST_PROG;
          end
        end
        ST_PROG: begin
          if (tmr_expire) begin
            flash_prog <= 1'b0;
            state      <= ST_DONE;
          end
        end
        ST_ERASE: begin
          if (tmr_expire) begin
            flash_erase <= 1'b0;
            state       <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (op == OP_WRITE) cur_addr <= cur_addr + STEP;
          if (hold_vld) begin
            op          <= OP_WRITE;
            flash_wdata <= hold_data;
            hold_vld    <= 1'b0;
            state       <= ST_CHECK;
          end else if (data_we) begin
            op          <= OP_WRITE;
            flash_wdata <= data_wdata;
            state       <= ST_CHECK;
          end else begin
            dma_req <= (op == OP_WRITE);
            busy    <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        ST_REJECT: begin
          hold_vld <= 1'b0;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int TIM_W  = 6,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              abort_clr,
  input logic [TIM_W-1:0]  timing_val,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              busy,
  input logic              abort_flag,
  input logic              dma_req,
  input logic              flash_prog,
  input logic              flash_erase
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DW / 8);

  // R12
  excl_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(flash_prog && flash_erase));

  // R9
  dma_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> !dma_req);

  // R9
  dma_idle_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> !busy);

  // R4
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_prog || flash_erase) |-> busy);

  // R11
  tim_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(timing_val));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(cur_addr)) |->
      (cur_addr == ADDR_W'($past(cur_addr) + STEP)));

  // R5
  abort_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (abort_flag && !abort_clr) |=> abort_flag);
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .TIM_W  (TIM_W),
  .DW     (DW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .abort_clr   (abort_clr),
  .timing_val  (timing_val),
  .cur_addr    (cur_addr),
  .busy        (busy),
  .abort_flag  (abort_flag),
  .dma_req     (dma_req),
  .flash_prog  (flash_prog),
  .flash_erase (flash_erase)
);

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;
  localparam int ESC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  lock_cfg = 8'h1F;
  logic        tim_we = 1'b0;
  logic [5:0]  tim_wdata = '0;
  logic        addr_we = 1'b0;
  logic [16:0] addr_wdata = '0;
  logic        data_we = 1'b0;
  logic [31:0] data_wdata = '0;
  logic        erase_start = 1'b0;
  logic        abort_clr = 1'b0;
  logic [5:0]  timing_val;
  logic [16:0] cur_addr;
  logic        busy, abort_flag, dma_req, flash_prog, flash_erase;
  logic [14:0] flash_waddr;
  logic [31:0] flash_wdata;

  int total = 0;
  int bad = 0;

  flash_prog_ctrl #(.ERASE_SCALE(ESC)) uut (
    .clk(clk), .rst(rst), .lock_cfg(lock_cfg),
    .tim_we(tim_we), .tim_wdata(tim_wdata),
    .addr_we(addr_we), .addr_wdata(addr_wdata),
    .data_we(data_we), .data_wdata(data_wdata),
    .erase_start(erase_start), .abort_clr(abort_clr),
    .timing_val(timing_val), .cur_addr(cur_addr), .busy(busy),
    .abort_flag(abort_flag), .dma_req(dma_req),
    .flash_waddr(flash_waddr), .flash_wdata(flash_wdata),
    .flash_prog(flash_prog), .flash_erase(flash_erase)
  );

  always #10 clk = ~clk;

  // pulse monitor
  int prog_cnt = 0, erase_cnt = 0, dma_cnt = 0;
  int prog_len = 0, erase_len = 0, run_len = 0;
  logic [14:0] prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic prev_p = 1'b0, prev_e = 1'b0;

  always @(negedge clk) begin
    if (dma_req) dma_cnt++;
    if (flash_prog && !prev_p) begin
      prog_cnt++; run_len = 1; prog_addr = flash_waddr; prog_data = flash_wdata;
    end else if (flash_erase && !prev_e) begin
      erase_cnt++; run_len = 1;
    end else if (flash_prog || flash_erase) run_len++;
    if (!flash_prog && prev_p) prog_len = run_len;
    if (!flash_erase && prev_e) erase_len = run_len;
    prev_p = flash_prog;
    prev_e = flash_erase;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_locked(input int page, input int code, input bit boot);
    int first;
    first = 64 - (64 >> code);
    return (page >= first) || (page == 0 && (!boot || code == 0));
  endfunction

  task automatic pulse_tim(input logic [5:0] v);
    @(negedge clk); tim_we = 1'b1; tim_wdata = v;
    @(negedge clk); tim_we = 1'b0;
  endtask

  task automatic pulse_addr(input logic [16:0] a);
    @(negedge clk); addr_we = 1'b1; addr_wdata = a;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic pulse_data(input logic [31:0] d);
    @(negedge clk); data_we = 1'b1; data_wdata = d;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic pulse_erase();
    @(negedge clk); erase_start = 1'b1;
    @(negedge clk); erase_start = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); abort_clr = 1'b1;
    @(negedge clk); abort_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 20000 && busy; g++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  // one request against the protection model; R2 R3 R4 R6 R7 R8
  task automatic run_case(input int code, input bit boot, input int page,
                          input bit erase, input string tag);
    logic [16:0] a0;
    logic [31:0] d;
    int pc, ec, dc;
    bit lk;
    lock_cfg = {3'b000, boot, 3'(code), 1'b1};
    pulse_clr();
    a0 = {6'(page), 9'($urandom), 2'b00};
    d  = $urandom;
    pulse_addr(a0);
    pc = prog_cnt; ec = erase_cnt; dc = dma_cnt;
    lk = exp_locked(page, code, boot);
    if (erase) pulse_erase(); else pulse_data(d);
    wait_idle();
    if (lk) begin
      chk({tag, " R4 abort"}, abort_flag, 1);
      chk({tag, " R4 no strobe"}, prog_cnt + erase_cnt, pc + ec);
      chk({tag, " R4 no dma"}, dma_cnt, dc);
      chk({tag, " R4 addr"}, cur_addr, a0);
    end else if (erase) begin
      chk({tag, " R7 erase count"}, erase_cnt, ec + 1);
      chk({tag, " R7 erase len"}, erase_len, timing_val * 16 * ESC);
      chk({tag, " R7 addr"}, cur_addr, a0);
      chk({tag, " R7 no dma"}, dma_cnt, dc);
      chk({tag, " R3 no abort"}, abort_flag, 0);
    end else begin
      chk({tag, " R6 prog count"}, prog_cnt, pc + 1);
      chk({tag, " R6 len"}, prog_len, timing_val * 16);
      chk({tag, " R6 waddr"}, prog_addr, a0[16:2]);
      chk({tag, " R6 data"}, prog_data, d);
      chk({tag, " R8 addr step"}, cur_addr, 17'(a0 + 4));
      chk({tag, " R9 dma"}, dma_cnt, dc + 1);
      chk({tag, " R2 no abort"}, abort_flag, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pc, dc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 abort", abort_flag, 0);
    chk("R1 timing", timing_val, 6'h2A);
    chk("R1 dma", dma_req, 0);
    chk("R1 strobes", {flash_prog, flash_erase}, 0);
    chk("R1 addr", cur_addr, 0);

    // R6 with the 16 MHz setting
    pulse_tim(6'h15);
    chk("R11 timing write idle", timing_val, 6'h15);
    run_case(7, 1'b1, 5, 1'b0, "t15 write");
    run_case(7, 1'b1, 5, 1'b1, "t15 erase");
    pulse_tim(6'd3);

    // R10 holding slot, third word dropped
    lock_cfg = 8'h1F;
    pulse_addr(17'h01000);
    pc = prog_cnt; dc = dma_cnt;
    pulse_data(32'hAAAA0001);
    pulse_data(32'hBBBB0002);
    pulse_data(32'hCCCC0003);
    wait_idle();
    chk("R10 two commits", prog_cnt, pc + 2);
    chk("R10 one dma", dma_cnt, dc + 1);
    chk("R10 held data", prog_data, 32'hBBBB0002);
    chk("R10 held addr", prog_addr, 15'h0401);
    chk("R10 R8 final addr", cur_addr, 17'h01008);

    // R11 writes ignored while busy
    pulse_addr(17'h02000);
    pulse_erase();
    pulse_tim(6'd9);
    pulse_addr(17'h03000);
    wait_idle();
    chk("R11 timing held", timing_val, 6'd3);
    chk("R11 addr held", cur_addr, 17'h02000);

    // R2 R3 boundary corners
    run_case(0, 1'b1, 0, 1'b0, "c000 p0 boot1");
    run_case(0, 1'b1, 31, 1'b0, "c000 p31");
    run_case(7, 1'b0, 0, 1'b0, "c111 p0 boot0");
    run_case(7, 1'b1, 0, 1'b0, "c111 p0 boot1");
    run_case(7, 1'b1, 63, 1'b1, "c111 p63");
    run_case(6, 1'b1, 62, 1'b0, "c110 p62");
    run_case(6, 1'b1, 63, 1'b0, "c110 p63");
    run_case(1, 1'b1, 31, 1'b1, "c001 p31");
    run_case(1, 1'b1, 32, 1'b1, "c001 p32");

    // R5 abort stays set across an allowed op, then clears
    run_case(6, 1'b1, 63, 1'b0, "R5 set");
    lock_cfg = 8'h1F;
    pulse_addr(17'h00800);
    pulse_data(32'h12345678);
    wait_idle();
    chk("R5 sticky", abort_flag, 1);
    pulse_clr();
    chk("R5 cleared", abort_flag, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      run_case(int'($urandom_range(7, 0)), 1'($urandom), int'($urandom_range(63, 0)),
               1'($urandom), $sformatf("rand%0d", i));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule